// File: doc/BRIEF.md
# Miss Handler Allocation Arbiter

This block owns a configurable pool of miss-status handling registers for a lockup-free data cache. Two kinds of requester compete for the pool: the processor's demand miss (a load or a store), of which at most one is ever outstanding because the processor stalls on it, and prefetch misses handed over by the prefetch issue buffer. Prefetches are queued inside the block in arrival order. Whenever a register is free, the block grants the lowest-numbered free register to one requester. It issues the line request to the memory side in the same cycle as the grant.

Priority is fixed. A grantable demand miss always takes the next free register. Without one, the oldest prefetch not yet serviced is granted. Each register holds one line request until the memory side reports completion by register index. That report releases the register and returns the stored line address. When the request was a prefetch, the same report also hands back the prefetch buffer index, so that the buffer can free its entry. A demand request is acknowledged only in its grant cycle, so the processor holds its request until a register is available.

Top module: `mha_alloc_arbiter`

## Requirements
- R1: After reset every register is free and no grant, acknowledgement or prefetch completion is signalled while no request is presented.
- R2: At most one grant is made per cycle, and it goes to the lowest-numbered free register; no grant is made while every register is busy.
- R3: In a cycle where a grantable demand miss and a queued prefetch both wait and a register is free, the demand miss is granted and the prefetch is not.
- R4: Prefetches are granted in the order in which they were pushed, each grant carrying that prefetch's line address and buffer index.
- R5: `dmd_ack` is high only in the cycle in which the held demand request is granted; while no register can be given, the request stays unacknowledged.
- R6: A completion frees its register at the next clock edge: the register is not granted in the completion cycle and can be granted from the next cycle on.
- R7: On a completion, `cmp_addr` returns the stored line address in the same cycle; `pf_done_valid` with the stored buffer index is raised in that cycle only when the released register held a prefetch.
- R8: While a demand miss holds a register, a new demand request is not granted, but queued prefetches may take free registers meanwhile.
- R9: A grant reports its type on `gnt_kind` (0 load, 1 store, 2 prefetch) together with the granted line address.
- R10: A prefetch pushed in a cycle cannot be granted in that same cycle; it becomes eligible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_req | input | 1 | Demand miss request, held until acknowledged |
| dmd_is_store | input | 1 | Demand miss is a store (1) or a load (0) |
| dmd_addr | input | ADDR_W | Line address of the demand miss |
| dmd_ack | output | 1 | Demand miss granted this cycle |
| pf_push | input | 1 | Prefetch buffer hands over a prefetch miss |
| pf_push_idx | input | PFB_IW | Prefetch buffer entry index of the pushed prefetch |
| pf_push_addr | input | ADDR_W | Line address of the pushed prefetch |
| gnt_valid | output | 1 | A register is granted and a line request issued |
| gnt_reg | output | REG_IW | Index of the granted register |
| gnt_kind | output | 2 | Request type: 0 load, 1 store, 2 prefetch |
| gnt_addr | output | ADDR_W | Line address of the issued request |
| gnt_pf_idx | output | PFB_IW | Buffer index of a granted prefetch, zero otherwise |
| cmp_valid | input | 1 | Memory side reports completion |
| cmp_reg | input | REG_IW | Register index of the completed request |
| cmp_addr | output | ADDR_W | Line address held by the completed register |
| pf_done_valid | output | 1 | The completed request was a prefetch |
| pf_done_idx | output | PFB_IW | Buffer index to release in the prefetch buffer |

## Verification
A register whose busy bit is stuck or cleared early shows in the grant index: the next grant goes to the wrong register or arrives in the wrong cycle. A stuck demand flag shows as a demand miss that is never acknowledged. A bad age queue shows within one grant as a prefetch address or buffer index out of push order. A corrupted stored field shows only when its register completes: `cmp_addr` or `pf_done_idx` is wrong in that cycle, or `pf_done_valid` is missing or spurious. A small pool of three registers and a four-deep buffer is swept through every fill level, with demand and prefetch collisions, so each of these faults is seen within a few cycles of its cause.

// File: rtl/mha_pkg.sv
// Shared definitions for the miss handler allocation arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package mha_pkg;

    typedef enum logic [1:0] {
        MISS_LOAD     = 2'd0,
        MISS_STORE    = 2'd1,
        MISS_PREFETCH = 2'd2
    } miss_kind_e;

    // Index width for a count of n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mha_age_queue.sv
// Circular queue that keeps pending prefetch misses in arrival order.
// Assumes: the producer never pushes into a full queue unless a pop happens
// in the same cycle, and pop is requested only while the queue is non-empty.
module mha_age_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          nonempty
);
    localparam int PW = mha_pkg::idx_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    assign nonempty = (count != '0);
    assign head     = slots[rd_ptr];

    // Store the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)) || pop);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);

endmodule

// File: rtl/mha_free_picker.sv
// Finds the lowest-numbered free register in the pool.
// Assumes: busy[i] is high for each register holding a request.
module mha_free_picker #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  busy,
    output logic          any_free,
    output logic [IW-1:0] pick
);
    // Scan from the top so the lowest free index is the one that remains.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) pick = IW'(i);
        end
    end

    assign any_free = ~&busy;

endmodule

// File: rtl/mha_entry_file.sv
// The miss-status register pool: valid bit, line address, request type and
// prefetch buffer index per register; allocation and release by index.
// Assumes: allocation targets a free register and completion a busy one.
module mha_entry_file #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int PW = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [IW-1:0] alloc_reg,
    input  logic [AW-1:0] alloc_addr,
    input  mha_pkg::miss_kind_e alloc_kind,
    input  logic [PW-1:0] alloc_pf_idx,
    input  logic          cmp_valid,
    input  logic [IW-1:0] cmp_reg,
    output logic [N-1:0]  busy,
    output logic          dmd_busy,
    output logic [AW-1:0] cmp_addr,
    output logic          pf_done_valid,
    output logic [PW-1:0] pf_done_idx
);
    import mha_pkg::*;

    logic [N-1:0]  valid_q;
    logic [AW-1:0] addr_q [N];
    miss_kind_e    kind_q [N];
    logic [PW-1:0] pfidx_q [N];
    logic [N-1:0]  rel_hit;
    logic [N-1:0]  is_dmd;

    // Decode completion and demand occupancy per register.
    for (genvar g = 0; g < N; g++) begin : g_decode
        assign rel_hit[g] = cmp_valid && (cmp_reg == IW'(g));
        assign is_dmd[g]  = valid_q[g] && (kind_q[g] != MISS_PREFETCH);
    end

    assign busy     = valid_q;
    assign dmd_busy = |is_dmd;

    // Release on completion, fill on allocation.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                kind_q[i]  <= MISS_LOAD;
                addr_q[i]  <= '0;
                pfidx_q[i] <= '0;
            end else if (rel_hit[i]) begin
                valid_q[i] <= 1'b0;
            end else if (alloc && alloc_reg == IW'(i)) begin
                valid_q[i] <= 1'b1;
                addr_q[i]  <= alloc_addr;
                kind_q[i]  <= alloc_kind;
                pfidx_q[i] <= alloc_pf_idx;
            end
        end
    end

    // Read out the contents of the register being released.
    always_comb begin
        cmp_addr      = '0;
        pf_done_valid = 1'b0;
        pf_done_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (rel_hit[i]) begin
                cmp_addr      = addr_q[i];
                pf_done_valid = valid_q[i] && (kind_q[i] == MISS_PREFETCH);
                pf_done_idx   = pfidx_q[i];
            end
        end
    end

    // R6
    cmp_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> |(busy & rel_hit));

    // R6
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> !busy[$past(cmp_reg)]);

    // R8
    single_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_dmd) <= 1);

endmodule

// File: rtl/mha_alloc_arbiter.sv
// Top of the miss handler allocation arbiter: queues prefetch misses by age,
// grants the lowest free register to the demand miss first, otherwise to
// the oldest queued prefetch, and reports completions.
// Assumes: 1 <= NUM_REGS <= 17; the prefetch buffer pushes each of its
// indices at most once until that index is reported done; dmd_req and its
// fields stay stable until dmd_ack.
module mha_alloc_arbiter #(
    parameter int NUM_REGS  = 4,
    parameter int ADDR_W    = 26,
    parameter int PFB_DEPTH = 16,
    localparam int REG_IW   = mha_pkg::idx_width(NUM_REGS),
    localparam int PFB_IW   = mha_pkg::idx_width(PFB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_req,
    input  logic              dmd_is_store,
    input  logic [ADDR_W-1:0] dmd_addr,
    output logic              dmd_ack,
    input  logic              pf_push,
    input  logic [PFB_IW-1:0] pf_push_idx,
    input  logic [ADDR_W-1:0] pf_push_addr,
    output logic              gnt_valid,
    output logic [REG_IW-1:0] gnt_reg,
    output logic [1:0]        gnt_kind,
    output logic [ADDR_W-1:0] gnt_addr,
    output logic [PFB_IW-1:0] gnt_pf_idx,
    input  logic              cmp_valid,
    input  logic [REG_IW-1:0] cmp_reg,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic              pf_done_valid,
    output logic [PFB_IW-1:0] pf_done_idx
);
    import mha_pkg::*;

    localparam int QW = ADDR_W + PFB_IW;

    logic [NUM_REGS-1:0] busy;
    logic                dmd_busy;
    logic                any_free;
    logic [REG_IW-1:0]   free_reg;
    logic                q_nonempty;
    logic [QW-1:0]       q_head;
    logic                take_dmd, take_pf;
    miss_kind_e          kind;

    mha_age_queue #(.DEPTH(PFB_DEPTH), .DW(QW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(pf_push), .push_data({pf_push_addr, pf_push_idx}),
        .pop(take_pf), .head(q_head), .nonempty(q_nonempty)
    );

    mha_free_picker #(.N(NUM_REGS), .IW(REG_IW)) u_picker (
        .busy(busy), .any_free(any_free), .pick(free_reg)
    );

    // Fixed priority: eligible demand first, then the oldest prefetch.
    always_comb begin
        take_dmd = dmd_req && !dmd_busy && any_free;
        take_pf  = !take_dmd && q_nonempty && any_free;
        if (take_dmd) kind = dmd_is_store ? MISS_STORE : MISS_LOAD;
        else          kind = MISS_PREFETCH;
    end

    assign dmd_ack    = take_dmd;
    assign gnt_valid  = take_dmd || take_pf;
    assign gnt_reg    = free_reg;
    assign gnt_kind   = kind;
    assign gnt_addr   = take_dmd ? dmd_addr : q_head[QW-1:PFB_IW];
    assign gnt_pf_idx = take_pf ? q_head[PFB_IW-1:0] : '0;

    mha_entry_file #(.N(NUM_REGS), .AW(ADDR_W), .PW(PFB_IW), .IW(REG_IW)) u_file (
        .clk(clk), .rst_n(rst_n),
        .alloc(gnt_valid), .alloc_reg(free_reg), .alloc_addr(gnt_addr),
        .alloc_kind(kind), .alloc_pf_idx(gnt_pf_idx),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg),
        .busy(busy), .dmd_busy(dmd_busy), .cmp_addr(cmp_addr),
        .pf_done_valid(pf_done_valid), .pf_done_idx(pf_done_idx)
    );

    // R2
    grant_to_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !busy[gnt_reg]);

    // R2
    grant_takes_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> busy[$past(gnt_reg)]);

    // R3
    demand_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_req && !dmd_busy && !dmd_ack) |-> !gnt_valid);

    // R5
    ack_is_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmd_ack |-> gnt_valid && gnt_kind != 2'd2);

    // R7
    done_needs_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_done_valid |-> cmp_valid);

endmodule

// File: tb/mha_alloc_arbiter_test.sv
`timescale 1ns/100ps
module mha_alloc_arbiter_test;
    localparam int NR = 3;
    localparam int PD = 4;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dmd_req = 0, dmd_is_store = 0;
    logic [AW-1:0] dmd_addr = '0;
    logic dmd_ack;
    logic pf_push = 0;
    logic [PW-1:0] pf_push_idx = '0;
    logic [AW-1:0] pf_push_addr = '0;
    logic gnt_valid;
    logic [IW-1:0] gnt_reg;
    logic [1:0] gnt_kind;
    logic [AW-1:0] gnt_addr;
    logic [PW-1:0] gnt_pf_idx;
    logic cmp_valid = 0;
    logic [IW-1:0] cmp_reg = '0;
    logic [AW-1:0] cmp_addr;
    logic pf_done_valid;
    logic [PW-1:0] pf_done_idx;

    always #2.5 clk = ~clk;

    mha_alloc_arbiter #(.NUM_REGS(NR), .ADDR_W(AW), .PFB_DEPTH(PD)) uut (.*);

    int tests = 0, fails = 0;
    bit done_flag = 0;
    // Requirement model of the pool
    bit mv[NR]; bit mpf[NR]; int maddr[NR]; int midx[NR];
    int q_idx[$]; int q_addr[$];
    bit inuse[PD];
    // Port samples from the last cycle
    int s_gv, s_reg, s_kind, s_ack, s_done, s_didx, s_caddr;

    task automatic chk(string tag, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // One clock: inputs set at the falling edge, checked 1 ns later.
    task automatic cycle();
        int f = -1;
        bit bd = 0, ed, ep, exd;
        #1;
        s_gv = gnt_valid; s_reg = gnt_reg; s_kind = gnt_kind; s_ack = dmd_ack;
        s_done = pf_done_valid; s_didx = pf_done_idx; s_caddr = cmp_addr;
        for (int i = 0; i < NR; i++) begin
            if (!mv[i] && f < 0) f = i;
            if (mv[i] && !mpf[i]) bd = 1;
        end
        ed = dmd_req && !bd && f >= 0;
        ep = !ed && q_idx.size() > 0 && f >= 0;
        chk("R5", int'(dmd_ack), int'(ed), "dmd_ack");
        chk("R2", int'(gnt_valid), int'(ed || ep), "gnt_valid");
        if (ed || ep) chk("R2", int'(gnt_reg), f, "gnt_reg");
        if (ed) begin
            chk("R9", int'(gnt_kind), dmd_is_store ? 1 : 0, "gnt_kind demand");
            chk("R9", int'(gnt_addr), int'(dmd_addr), "gnt_addr demand");
        end
        if (ep) begin
            chk("R3", int'(gnt_kind), 2, "gnt_kind prefetch");
            chk("R4", int'(gnt_addr), q_addr[0], "gnt_addr prefetch");
            chk("R4", int'(gnt_pf_idx), q_idx[0], "gnt_pf_idx");
        end
        exd = cmp_valid && mv[cmp_reg] && mpf[cmp_reg];
        chk("R7", int'(pf_done_valid), int'(exd), "pf_done_valid");
        if (exd) chk("R7", int'(pf_done_idx), midx[cmp_reg], "pf_done_idx");
        if (cmp_valid) chk("R7", int'(cmp_addr), maddr[cmp_reg], "cmp_addr");
        // Advance the model
        if (cmp_valid) begin
            mv[cmp_reg] = 0;
            if (exd) inuse[midx[cmp_reg]] = 0;
        end
        if (ed) begin
            mv[f] = 1; mpf[f] = 0; maddr[f] = dmd_addr; midx[f] = 0;
        end
        if (ep) begin
            mv[f] = 1; mpf[f] = 1; maddr[f] = q_addr[0]; midx[f] = q_idx[0];
            void'(q_idx.pop_front()); void'(q_addr.pop_front());
        end
        if (pf_push) begin
            q_idx.push_back(pf_push_idx); q_addr.push_back(pf_push_addr);
        end
        @(negedge clk);
        if (ed) dmd_req = 0;
        pf_push = 0;
        cmp_valid = 0;
    endtask

    task automatic push_pf(int idx, int addr);
        pf_push = 1; pf_push_idx = PW'(idx); pf_push_addr = AW'(addr);
        inuse[idx] = 1;
    endtask

    task automatic complete(int r);
        cmp_valid = 1; cmp_reg = IW'(r);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        cycle();
        chk("R1", s_gv, 0, "gnt_valid after reset");
        chk("R1", s_ack + s_done, 0, "ack/done after reset");
        // R10: a pushed prefetch is not granted in its push cycle
        push_pf(0, 'h40);
        cycle();
        chk("R10", s_gv, 0, "grant in push cycle");
        cycle();
        chk("R4", s_reg, 0, "first prefetch register");
        chk("R4", s_kind, 2, "first prefetch kind");
        // R3: demand beats a queued prefetch
        push_pf(1, 'h41);
        cycle();
        dmd_req = 1; dmd_is_store = 0; dmd_addr = 'h80;
        cycle();
        chk("R3", s_kind, 0, "demand wins over prefetch");
        chk("R3", s_reg, 1, "demand register");
        // R8: a second demand waits while prefetch takes the last register
        dmd_req = 1; dmd_is_store = 1; dmd_addr = 'h81;
        cycle();
        chk("R8", s_ack, 0, "second demand ack");
        chk("R8", s_kind, 2, "prefetch granted meanwhile");
        chk("R8", s_reg, 2, "prefetch register");
        // R5: pool full, request held unacknowledged
        cycle();
        chk("R5", s_ack + s_gv, 0, "full pool grant");
        // R6/R7: prefetch completion on register 0
        complete(0);
        cycle();
        chk("R7", s_done, 1, "prefetch done flag");
        chk("R7", s_didx, 0, "prefetch done index");
        chk("R7", s_caddr, 'h40, "completed address");
        chk("R6", s_gv, 0, "grant in completion cycle");
        // Demand completion: no prefetch done
        complete(1);
        cycle();
        chk("R7", s_done, 0, "demand completion done flag");
        cycle();
        chk("R6", s_ack, 1, "demand granted after release");
        chk("R6", s_reg, 0, "lowest freed register");
        chk("R9", s_kind, 1, "store kind");
        // Near-exhaustive random sweep over fill levels and collisions
        for (int n = 0; n < 6000; n++) begin
            int r;
            if (!dmd_req && ($urandom % 4 == 0)) begin
                dmd_req = 1; dmd_is_store = 1'($urandom);
                dmd_addr = AW'($urandom);
            end
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < PD; k++) begin
                    if (!inuse[k] && !pf_push) push_pf(k, $urandom % 256);
                end
            end
            r = $urandom % NR;
            if (mv[r] && ($urandom % 3 != 0)) complete(r);
            cycle();
        end
        finish_run();
    end
endmodule